// File: doc/BRIEF.md
# Page Write Sequencer with In-Page Wrap

This block sits behind the serial front-end of a byte-wide serial memory and handles the array-write command. When the front-end decodes a write command and its start address, the sequencer opens a page buffer. It then stores each incoming data byte at a page-relative offset. Only the low offset bits advance, so a long burst wraps around inside the same page and replaces bytes it stored earlier.

The rising edge of chip select is the only point where a write can be committed, and it counts only when no partial byte is pending. A commit starts a self-timed busy period of a set number of clock cycles. After that period the sequencer walks the page slots in ascending order and issues one array write per stored byte. At the end of the cycle it pulses a request that clears the write-enable latch. Protection is decided outside the block: for every byte the sequencer presents the byte's address, and the answer decides whether that slot is programmed. A command that arrives while the latch is clear is absorbed until chip select rises, and no write takes place.

Top module: `page_wr_seq`

## Requirements
- R1: After reset, `busy`, `wel_clr` and `mem_we` are all low.
- R2: On a write command with `wel_i` high, the data bytes go to slots starting at offset `cmd_addr[PB-1:0]`, and each later byte uses the next offset. At commit each stored byte is written to address `{cmd_addr[AW-1:PB], offset}`. The upper bits never change, so offset PAGE-1 is followed by offset 0 of the same page.
- R3: When more than PAGE bytes arrive, a later byte replaces the earlier byte in the same slot. Every slot address is written at most once per commit, and it carries the newest data.
- R4: A commit happens only when `cs_rise` is sampled high while `partial_bits` is low. If `partial_bits` is high, the command is dropped: no busy period, no array write and no `wel_clr`.
- R5: A write command seen while `wel_i` is low has no effect. Bytes that follow it are discarded, and the next `cs_rise` returns the block to idle, ready for a new command.
- R6: After a commit, `busy` rises in the cycle after the `cs_rise` sample and stays high for exactly WR_CYCLES + PAGE + 1 cycles. The first WR_CYCLES cycles issue no write. In the next PAGE cycles slot k is visited in cycle WR_CYCLES + k, and `mem_we` is high there only if the slot holds a byte to program.
- R7: `wel_clr` pulses for exactly one cycle, in the last busy cycle of a committed write. It never pulses for a dropped or ignored command.
- R8: A byte whose address gets `prot_hit` high (address shown on `prot_addr` while the byte is accepted) is never written. Unprotected bytes of the same page are still written. If every stored byte is protected, or no byte was received (R10), `cs_rise` starts no busy period.
- R9: While `busy` is high, `cmd_valid`, `byte_valid` and `cs_rise` have no effect on the array writes or on the busy length.
- R10: A `cs_rise` right after a command with no data byte commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: write command decoded with its address |
| cmd_addr | input | AW | Start byte address of the write |
| wel_i | input | 1 | Current state of the write-enable latch |
| byte_valid | input | 1 | One-cycle strobe: a complete data byte is available |
| byte_data | input | DW | Data byte |
| cs_rise | input | 1 | One-cycle strobe: chip select went inactive |
| partial_bits | input | 1 | High when bits of an unfinished byte are pending |
| prot_addr | output | AW | Address of the byte being accepted, for the protection lookup |
| prot_hit | input | 1 | High when `prot_addr` lies in a protected region |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
Every result is timed from the clock edge that samples `cs_rise`. `busy` is already high at the following falling edge. The first array write appears WR_CYCLES falling edges after that, and later writes follow slot by slot. `wel_clr` shows up on the last busy falling edge. The bench drives a stimulus on one falling edge and removes it on the next. It counts busy, write and clear events on every falling edge from the commit onward, and the write monitor compares each `mem_we` against the head of an expected queue. That queue is filled in slot order at commit time. For dropped or ignored commands, the bench watches a window longer than a full cycle and requires busy, writes and clears to stay absent.

// File: rtl/pws_pkg.sv
package pws_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_FILL,
        PS_DROP,
        PS_WAIT,
        PS_PROG,
        PS_DONE
    } pws_state_e;

endpackage

// File: rtl/pws_busy_timer.sv
module pws_busy_timer #(
    parameter int CYCLES = 500000,
    parameter int TW     = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = TW'(CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pws_page_buf.sv
module pws_page_buf #(
    parameter int PB = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [PB-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_keep,
    input  logic [PB-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    output logic          rd_keep
);

    localparam int PAGE = 1 << PB;

    logic [DW-1:0]   dat_q [PAGE];
    logic [PAGE-1:0] keep_q;

    genvar s;
    generate
        for (s = 0; s < PAGE; s++) begin : g_slot
            logic          hit;
            logic [DW-1:0] dat_d;
            logic          keep_d;

            assign hit = wr_en && (wr_idx == PB'(s));

            always_comb begin
                dat_d  = dat_q[s];
                keep_d = clr ? 1'b0 : keep_q[s];
                if (hit) begin
                    dat_d  = wr_data;
                    keep_d = wr_keep;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    dat_q[s]  <= '0;
                    keep_q[s] <= 1'b0;
                end else begin
                    dat_q[s]  <= dat_d;
                    keep_q[s] <= keep_d;
                end
            end
        end
    endgenerate

    assign rd_data = dat_q[rd_idx];
    assign rd_keep = keep_q[rd_idx];

endmodule

// File: rtl/page_wr_seq.sv
module page_wr_seq
    import pws_pkg::*;
#(
    parameter int AW        = 15,
    parameter int PB        = 6,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 500000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [AW-1:0] cmd_addr,
    input  logic          wel_i,
    input  logic          byte_valid,
    input  logic [DW-1:0] byte_data,
    input  logic          cs_rise,
    input  logic          partial_bits,
    output logic [AW-1:0] prot_addr,
    input  logic          prot_hit,
    output logic          busy,
    output logic          wel_clr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);

    localparam int PAGE = 1 << PB;
    localparam int HW   = AW - PB;
    localparam int TW   = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        pws_state_e    st;
        logic [HW-1:0] base;
        logic [PB-1:0] off;
        logic          kept;
        logic [PB-1:0] idx;
    } ctl_t;

    ctl_t c_d, c_q;

    logic          buf_clr;
    logic          buf_wr;
    logic          tmr_load;
    logic          tmr_zero;
    logic [DW-1:0] rd_data;
    logic          rd_keep;
    logic          kept_now;

    pws_busy_timer #(
        .CYCLES (WR_CYCLES),
        .TW     (TW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .zero  (tmr_zero)
    );

    pws_page_buf #(
        .PB (PB),
        .DW (DW)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (c_q.off),
        .wr_data (byte_data),
        .wr_keep (!prot_hit),
        .rd_idx  (c_q.idx),
        .rd_data (rd_data),
        .rd_keep (rd_keep)
    );

    always_comb begin
        c_d      = c_q;
        buf_clr  = 1'b0;
        buf_wr   = 1'b0;
        tmr_load = 1'b0;
        kept_now = c_q.kept;
        unique case (c_q.st)
            PS_IDLE: begin
                if (cmd_valid) begin
                    c_d.base = cmd_addr[AW-1:PB];
                    c_d.off  = cmd_addr[PB-1:0];
                    c_d.kept = 1'b0;
                    if (wel_i) begin
                        c_d.st  = PS_FILL;
                        buf_clr = 1'b1;
                    end else begin
                        c_d.st  = PS_DROP;
                    end
                end
            end
            PS_FILL: begin
                if (byte_valid) begin
                    buf_wr  = 1'b1;
                    c_d.off = c_q.off + 1'b1;
                    if (!prot_hit) kept_now = 1'b1;
                end
                c_d.kept = kept_now;
                if (cs_rise) begin
                    if (!partial_bits && kept_now) begin
                        c_d.st   = PS_WAIT;
                        tmr_load = 1'b1;
                    end else begin
                        c_d.st   = PS_IDLE;
                    end
                end
            end
            PS_DROP: begin
                if (cs_rise) c_d.st = PS_IDLE;
            end
            PS_WAIT: begin
                if (tmr_zero) begin
                    c_d.st  = PS_PROG;
                    c_d.idx = '0;
                end
            end
            PS_PROG: begin
                c_d.idx = c_q.idx + 1'b1;
                if (c_q.idx == PB'(PAGE - 1)) c_d.st = PS_DONE;
            end
            PS_DONE: begin
                c_d.st = PS_IDLE;
            end
            default: c_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= PS_IDLE;
            c_q.base <= '0;
            c_q.off  <= '0;
            c_q.kept <= 1'b0;
            c_q.idx  <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign prot_addr = {c_q.base, c_q.off};
    assign busy      = (c_q.st == PS_WAIT) || (c_q.st == PS_PROG) || (c_q.st == PS_DONE);
    assign wel_clr   = (c_q.st == PS_DONE);
    assign mem_we    = (c_q.st == PS_PROG) && rd_keep;
    assign mem_addr  = {c_q.base, c_q.idx};
    assign mem_wdata = rd_data;

endmodule

// File: rtl/pws_checker.sv
module pws_checker #(
    parameter int AW = 15,
    parameter int PB = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_rise,
    input logic          partial_bits,
    input logic          busy,
    input logic          wel_clr,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr
);

    p_we_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_slot_ascend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[PB-1:0] > $past(mem_addr[PB-1:0])));

    p_commit_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(cs_rise) && !$past(partial_bits)));

    p_clr_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> (!busy && !wel_clr));

    p_fall_after_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wel_clr));

    p_page_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[AW-1:PB] == $past(mem_addr[AW-1:PB])));

endmodule

bind page_wr_seq pws_checker #(
    .AW (AW),
    .PB (PB)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_rise      (cs_rise),
    .partial_bits (partial_bits),
    .busy         (busy),
    .wel_clr      (wel_clr),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
);

// File: tb/page_wr_seq_tb.sv
module page_wr_seq_tb;

    localparam int AW   = 15;
    localparam int PB   = 6;
    localparam int DW   = 8;
    localparam int TWR  = 20;
    localparam int PAGE = 1 << PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          wel_i = 1'b0;
    logic          byte_valid = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          partial_bits = 1'b0;
    logic [AW-1:0] prot_addr;
    logic          prot_hit;
    logic          busy, wel_clr, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic          prot_en = 1'b0;
    logic [AW-1:0] prot_lim = '0;

    assign prot_hit = prot_en && (prot_addr >= prot_lim);

    always #5 clk = ~clk;

    page_wr_seq #(.AW(AW), .PB(PB), .DW(DW), .WR_CYCLES(TWR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .wel_i(wel_i), .byte_valid(byte_valid), .byte_data(byte_data),
        .cs_rise(cs_rise), .partial_bits(partial_bits), .prot_addr(prot_addr),
        .prot_hit(prot_hit), .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [AW+DW-1:0] exp_q[$];

    logic [DW-1:0]     m_dat [PAGE];
    logic [PAGE-1:0]   m_keep;
    logic [AW-PB-1:0]  tb_base;
    logic [PB-1:0]     tb_off;
    bit                tb_fill, tb_any;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // scoreboard monitor: every array write must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected write", {mem_addr, mem_wdata}, 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk({mem_addr, mem_wdata} == e, "R3", "array write", {mem_addr, mem_wdata}, e);
            end
        end
    end

    task automatic send_cmd(input logic [AW-1:0] a, input bit wel);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a; wel_i = wel;
        if (wel) begin
            m_keep = '0; tb_fill = 1'b1; tb_any = 1'b0;
            tb_base = a[AW-1:PB]; tb_off = a[PB-1:0];
        end else begin
            tb_fill = 1'b0;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [DW-1:0] d);
        logic [AW-1:0] a;
        a = {tb_base, tb_off};
        if (tb_fill) begin
            m_dat[tb_off]  = d;
            m_keep[tb_off] = !(prot_en && (a >= prot_lim));
            if (m_keep[tb_off]) tb_any = 1'b1;
            tb_off = tb_off + 1'b1;
        end
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic cs_up(input bit partial, output bit commit);
        commit = tb_fill && !partial && tb_any;
        if (commit) begin
            for (int s = 0; s < PAGE; s++) begin
                if (m_keep[s]) exp_q.push_back({tb_base, PB'(s), m_dat[s]});
            end
        end
        tb_fill = 1'b0;
        @(negedge clk);
        cs_rise = 1'b1; partial_bits = partial;
        @(negedge clk);
        cs_rise = 1'b0; partial_bits = 1'b0;
    endtask

    // counts busy / clear / first write position from the first falling edge after cs_rise
    task automatic observe(input bit commit, input bit poke, input string tag);
        int nb = 0, nc = 0, first = -1;
        for (int i = 0; i < TWR + PAGE + 20; i++) begin
            if (busy) nb++;
            if (wel_clr) nc++;
            if (mem_we && first < 0) first = i;
            if (poke) begin
                cmd_valid  = (i == 2);
                cmd_addr   = '0;
                wel_i      = 1'b1;
                byte_valid = (i == 3);
                byte_data  = 8'hEE;
                cs_rise    = (i == 4);
            end
            @(negedge clk);
        end
        if (commit) begin
            chk(nb == TWR + PAGE + 1, "R6", {tag, " busy length"}, nb, TWR + PAGE + 1);
            chk(nc == 1, "R7", {tag, " clear pulses"}, nc, 1);
            chk(first >= TWR, "R6", {tag, " first write slot"}, first, TWR);
        end else begin
            chk(nb == 0, tag, "busy cycles", nb, 0);
            chk(nc == 0, "R7", {tag, " clear pulses"}, nc, 0);
        end
        chk(exp_q.size() == 0, tag, "writes still pending", exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit c;
        tb_fill = 1'b0; tb_any = 1'b0; m_keep = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !wel_clr && !mem_we, "R1", "outputs in reset", {busy, wel_clr, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !wel_clr && !mem_we, "R1", "outputs after reset", {busy, wel_clr, mem_we}, 0);

        // R2: short burst inside one page; R9: traffic during busy is ignored
        send_cmd(15'h0123, 1'b1);
        for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
        cs_up(1'b0, c);
        chk(c, "R2", "model commit", c, 1);
        observe(c, 1'b1, "R9");

        // R2: wrap from the last offset to the first of the same page
        send_cmd(15'h0FFE, 1'b1);
        for (int i = 0; i < 5; i++) send_byte(8'hA0 + 8'(i));
        cs_up(1'b0, c);
        observe(c, 1'b0, "R2");

        // R3: overflow past a full page
        send_cmd(15'h028A, 1'b1);
        for (int i = 0; i < PAGE + 2; i++) send_byte(8'(i) ^ 8'h5A);
        cs_up(1'b0, c);
        observe(c, 1'b0, "R3");

        // R4: cs rises with a partial byte pending
        send_cmd(15'h0300, 1'b1);
        send_byte(8'h11); send_byte(8'h22);
        cs_up(1'b1, c);
        observe(c, 1'b0, "R4");

        // R5: latch clear at command, then a normal command is accepted
        send_cmd(15'h0400, 1'b0);
        send_byte(8'h33); send_byte(8'h44);
        cs_up(1'b0, c);
        observe(c, 1'b0, "R5");
        send_cmd(15'h0410, 1'b1);
        send_byte(8'h55);
        cs_up(1'b0, c);
        observe(c, 1'b0, "R5");

        // R8: mixed protection within one page
        prot_en = 1'b1; prot_lim = 15'h7FE0;
        send_cmd(15'h7FDE, 1'b1);
        for (int i = 0; i < 4; i++) send_byte(8'hC0 + 8'(i));
        cs_up(1'b0, c);
        observe(c, 1'b0, "R8");

        // R8: every byte protected
        send_cmd(15'h7FF0, 1'b1);
        send_byte(8'h66); send_byte(8'h77);
        cs_up(1'b0, c);
        observe(c, 1'b0, "R8");
        prot_en = 1'b0;

        // R10: no data byte at all
        send_cmd(15'h0500, 1'b1);
        cs_up(1'b0, c);
        observe(c, 1'b0, "R10");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule